// File: doc/BRIEF.md
# Flash Operation Sequencer

This block sits between a software command interface and a flash back end. Software gives it a byte start address, a word count and an operation type. The block then issues single-word requests to the back end, one at a time. For each word it holds the request, address and program data steady until the back end returns a done pulse for that kind of operation. Read data is written into a read FIFO, and program data is taken from a program FIFO. A transaction may cover far more words than either FIFO holds. In that case the sequencer pauses while the read FIFO is full or the program FIFO is empty, and resumes by itself once the condition clears.

Page erase and bank erase each issue a single request. Before any request, the start address is rounded down to the boundary that matches the operation type. Six interrupt state bits record FIFO events, level crossings, completion and error. Each bit can be cleared by writing 1, masked by an enable, and forced through a test input. Sticky done and error status bits report how the last command ended. A FIFO reset input empties both FIFOs without stopping the transaction that is running.

Top module: `flash_op_sequencer`

## Requirements
- R1: `cmd_op` selects the operation: 0 is read, 1 is program and 2 is erase. For an erase, `cmd_bank_sel` = 0 selects page erase and 1 selects bank erase. Exactly one of `fl_rd`, `fl_prog`, `fl_pg_erase` and `fl_bk_erase` is high while `fl_req` is high. Code 3 is reserved. It sets `op_err` and interrupt bit 5 without issuing any request.
- R2: `cmd_start` is accepted only while `busy` is low. A start while busy has no effect. A read or program issues exactly `cmd_count` requests (12-bit field). A count of 0 completes at once with done status and no request.
- R3: The start address is rounded down before use. Read and program round to a 4-byte word (0x13 becomes 0x10). Page erase rounds to a 1024-byte page. Bank erase rounds to a 256 KiB bank.
- R4: `fl_req`, `fl_addr`, `fl_wdata` and the kind lines stay stable until the done pulse that matches the kind. Each following word address is 4 higher, and page boundaries are crossed without any check.
- R5: No read request is made while the read FIFO holds 16 entries. Reading resumes once software pops an entry.
- R6: No program request starts while the program FIFO is empty. Program words go to the back end in the order they were pushed.
- R7: Read data enters the 16-entry read FIFO in address order. `rd_rdata` shows the oldest entry, and `rd_pop` removes it.
- R8: An erase issues exactly one request, whatever the count. It completes on `fl_erase_done`.
- R9: On completion `op_done` and interrupt bit 4 are set. `status_clr[0]` clears `op_done` and `status_clr[1]` clears `op_err`.
- R10: Interrupt bits are 0 program empty, 1 program level, 2 read full, 3 read level, 4 op done and 5 op error. Writing 1 to a bit of `intr_clr` clears that bit. A 1 on a bit of `intr_test` sets that bit. `irq` = `intr_state` & `intr_en`.
- R11: Bit 0 is set when the program FIFO becomes empty. Bit 1 is set when program occupancy falls to or below the program threshold. Bit 2 is set when the read FIFO reaches 16 entries. Bit 3 is set when read occupancy rises to or above the read threshold. Both 5-bit thresholds reset to 15, are loaded by `lvl_wr`, and none of these bits is set out of reset.
- R12: `fifo_clr` empties both FIFOs by the next cycle. A transaction in flight continues, and the program word already issued stays on `fl_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse for a command |
| cmd_op | input | 2 | Operation code |
| cmd_bank_sel | input | 1 | Erase scope: 0 page, 1 bank |
| cmd_count | input | 12 | Number of words to read or program |
| cmd_addr | input | 32 | Byte start address |
| fifo_clr | input | 1 | Empty both FIFOs |
| lvl_wr | input | 1 | Load both level thresholds |
| lvl_prog_thr | input | 5 | Program FIFO level threshold |
| lvl_rd_thr | input | 5 | Read FIFO level threshold |
| prog_push | input | 1 | Push a program word (dropped when full) |
| prog_wdata | input | 32 | Program word to push |
| prog_full | output | 1 | Program FIFO full |
| prog_empty | output | 1 | Program FIFO empty |
| rd_pop | input | 1 | Pop the oldest read word |
| rd_rdata | output | 32 | Oldest read word |
| rd_full | output | 1 | Read FIFO full |
| rd_empty | output | 1 | Read FIFO empty |
| intr_en | input | 6 | Interrupt enables |
| intr_clr | input | 6 | Write-1-to-clear strobes |
| intr_test | input | 6 | Force strobes |
| intr_state | output | 6 | Interrupt state bits |
| irq | output | 6 | Enabled interrupt lines |
| status_clr | input | 2 | Clear done (bit 0) and error (bit 1) |
| op_done | output | 1 | Sticky completion status |
| op_err | output | 1 | Sticky error status |
| busy | output | 1 | Transaction in progress |
| fl_req | output | 1 | Back-end request |
| fl_addr | output | 32 | Back-end byte address |
| fl_rd | output | 1 | Request is a read |
| fl_prog | output | 1 | Request is a program |
| fl_pg_erase | output | 1 | Request is a page erase |
| fl_bk_erase | output | 1 | Request is a bank erase |
| fl_wdata | output | 32 | Program data |
| fl_rd_done | input | 1 | Read done pulse |
| fl_prog_done | input | 1 | Program done pulse |
| fl_erase_done | input | 1 | Erase done pulse |
| fl_rdata | input | 32 | Read data, valid with `fl_rd_done` |

## Verification
The hardest situation to reach is a program FIFO reset while a program word is in flight. The bench must first reach the state where the word has already been taken from the FIFO and the back end is still working on it, and only then pulse `fifo_clr`. To get there, the bench's back-end model uses a long latency, the bench waits until it sees `fl_req` high, and it then pulses `fifo_clr`. It checks that `fl_wdata` does not change and that the words pushed after the reset are the ones programmed next. The stall paths are reached the same way: the bench withholds pops until the read FIFO fills, and feeds program words in short bursts. Random transactions from a fixed seed then mix random latencies, pop and push gaps, and counts larger than the FIFO depth.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int ADDR_W   = 32;
    localparam int NUM_INTR = 6;

    // interrupt bit positions
    localparam int IX_PROG_EMPTY = 0;
    localparam int IX_PROG_LVL   = 1;
    localparam int IX_RD_FULL    = 2;
    localparam int IX_RD_LVL     = 3;
    localparam int IX_OP_DONE    = 4;
    localparam int IX_OP_ERR     = 5;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic prog;
        logic pg_erase;
        logic bk_erase;
    } req_kind_t;

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input int unsigned log2_gran);
        logic [ADDR_W-1:0] keep;
        keep = {ADDR_W{1'b1}} << log2_gran;
        return a & keep;
    endfunction

    function automatic req_kind_t kind_of(input op_e op, input logic bank);
        req_kind_t k;
        k = '0;
        case (op)
            OP_READ:  k.rd = 1'b1;
            OP_PROG:  k.prog = 1'b1;
            OP_ERASE: begin
                k.pg_erase = ~bank;
                k.bk_erase = bank;
            end
            default:  k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/fsq_fifo.sv
module fsq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = cnt_q;
    assign rdata   = mem[rp_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp_q] <= wdata;
    end

endmodule

// File: rtl/fsq_intr.sv
module fsq_intr #(
    parameter int          N         = 6,
    parameter logic [N-1:0] EDGE_MASK = '0,
    parameter logic [N-1:0] COND_RST  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] test,
    input  logic [N-1:0] en,
    output logic [N-1:0] state,
    output logic [N-1:0] irq
);

    logic [N-1:0] evt;
    logic [N-1:0] state_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= COND_RST[i];
                else     prev_q <= cond[i];
            end
            assign evt[i] = cond[i] & ~prev_q;
        end else begin : g_pulse
            assign evt[i] = cond[i];
        end
    end

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= (state_q & ~clr) | evt | test;
    end

    assign state = state_q;
    assign irq   = state_q & en;

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
    import fsq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 12,
    parameter int WORD_LG = 2,
    parameter int PAGE_LG = 10,
    parameter int BANK_LG = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_bank,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        status_clr,
    input  logic              rd_fifo_full,
    input  logic              prog_fifo_empty,
    input  logic [DATA_W-1:0] prog_head,
    input  logic              fl_rd_done,
    input  logic              fl_prog_done,
    input  logic              fl_erase_done,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              rd_push,
    output logic [DATA_W-1:0] rd_push_data,
    output logic              prog_pop,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output req_kind_t         fl_kind,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              busy,
    output logic              done_evt,
    output logic              err_evt,
    output logic              stat_done,
    output logic              stat_err
);

    seq_state_e        st_q;
    req_kind_t         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [DATA_W-1:0] wdata_q;
    logic              sd_q, se_q;

    op_e               op_in;
    int unsigned       gran;
    logic [ADDR_W-1:0] aligned;
    logic              start_ok, zero_done, back_done, is_erase, last, can_issue, fin;

    assign op_in = op_e'(cmd_op);

    always_comb begin
        case (op_in)
            OP_ERASE: gran = cmd_bank ? BANK_LG : PAGE_LG;
            default:  gran = WORD_LG;
        endcase
    end
    assign aligned = align_down(cmd_addr, gran);

    assign is_erase  = kind_q.pg_erase | kind_q.bk_erase;
    assign back_done = (kind_q.rd & fl_rd_done) | (kind_q.prog & fl_prog_done)
                     | (is_erase & fl_erase_done);
    assign last      = is_erase || (rem_q == CNT_W'(1));
    assign can_issue = kind_q.rd ? !rd_fifo_full : !prog_fifo_empty;

    assign start_ok  = (st_q == ST_IDLE) && cmd_start;
    assign err_evt   = start_ok && (op_in == OP_RSVD);
    assign zero_done = start_ok && (op_in == OP_READ || op_in == OP_PROG) && (cmd_count == '0);
    assign fin       = (st_q == ST_WAIT) && back_done && last;
    assign done_evt  = zero_done || fin;

    assign rd_push      = (st_q == ST_WAIT) && back_done && kind_q.rd;
    assign rd_push_data = fl_rdata;
    assign prog_pop     = (st_q == ST_RUN) && kind_q.prog && !prog_fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            kind_q  <= '0;
            addr_q  <= '0;
            rem_q   <= '0;
            wdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        case (op_in)
                            OP_READ, OP_PROG: begin
                                if (cmd_count != '0) begin
                                    st_q   <= ST_RUN;
                                    rem_q  <= cmd_count;
                                    addr_q <= aligned;
                                    kind_q <= kind_of(op_in, cmd_bank);
                                end
                            end
                            OP_ERASE: begin
                                st_q   <= ST_WAIT;
                                addr_q <= aligned;
                                kind_q <= kind_of(op_in, cmd_bank);
                            end
                            default: ;
                        endcase
                    end
                end
                ST_RUN: begin
                    if (can_issue) begin
                        st_q <= ST_WAIT;
                        if (kind_q.prog) wdata_q <= prog_head;
                    end
                end
                ST_WAIT: begin
                    if (back_done) begin
                        if (last) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q   <= ST_RUN;
                            rem_q  <= rem_q - CNT_W'(1);
                            addr_q <= addr_q + (ADDR_W'(1) << WORD_LG);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_q <= 1'b0;
            se_q <= 1'b0;
        end else begin
            sd_q <= (sd_q & ~status_clr[0]) | done_evt;
            se_q <= (se_q & ~status_clr[1]) | err_evt;
        end
    end

    assign fl_req    = (st_q == ST_WAIT);
    assign fl_addr   = addr_q;
    assign fl_kind   = fl_req ? kind_q : '0;
    assign fl_wdata  = wdata_q;
    assign busy      = (st_q != ST_IDLE);
    assign stat_done = sd_q;
    assign stat_err  = se_q;

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import fsq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 12,
    parameter int WORD_BYTES = 4,
    parameter int PAGE_WORDS = 256,
    parameter int BANK_PAGES = 256,
    parameter int LVL_W      = 5,
    parameter int LVL_RESET  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_bank_sel,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [31:0]       cmd_addr,
    input  logic              fifo_clr,
    input  logic              lvl_wr,
    input  logic [LVL_W-1:0]  lvl_prog_thr,
    input  logic [LVL_W-1:0]  lvl_rd_thr,
    input  logic              prog_push,
    input  logic [DATA_W-1:0] prog_wdata,
    output logic              prog_full,
    output logic              prog_empty,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_rdata,
    output logic              rd_full,
    output logic              rd_empty,
    input  logic [5:0]        intr_en,
    input  logic [5:0]        intr_clr,
    input  logic [5:0]        intr_test,
    output logic [5:0]        intr_state,
    output logic [5:0]        irq,
    input  logic [1:0]        status_clr,
    output logic              op_done,
    output logic              op_err,
    output logic              busy,
    output logic              fl_req,
    output logic [31:0]       fl_addr,
    output logic              fl_rd,
    output logic              fl_prog,
    output logic              fl_pg_erase,
    output logic              fl_bk_erase,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_rd_done,
    input  logic              fl_prog_done,
    input  logic              fl_erase_done,
    input  logic [DATA_W-1:0] fl_rdata
);

    localparam int WORD_LG = $clog2(WORD_BYTES);
    localparam int PAGE_LG = WORD_LG + $clog2(PAGE_WORDS);
    localparam int BANK_LG = PAGE_LG + $clog2(BANK_PAGES);
    localparam int OCC_W   = $clog2(FIFO_DEPTH + 1);

    localparam logic [NUM_INTR-1:0] EDGE_MASK = NUM_INTR'((1 << IX_PROG_EMPTY) | (1 << IX_PROG_LVL)
                                                        | (1 << IX_RD_FULL) | (1 << IX_RD_LVL));
    // an empty program FIFO at or below the reset threshold is the quiet state
    localparam logic [NUM_INTR-1:0] COND_RST  = NUM_INTR'((1 << IX_PROG_EMPTY) | (1 << IX_PROG_LVL));

    logic [LVL_W-1:0]  prog_thr_q, rd_thr_q;
    logic [OCC_W-1:0]  prog_cnt, rd_cnt;
    logic [DATA_W-1:0] prog_head, rd_push_data;
    logic              rd_push, prog_pop;
    logic              done_evt, err_evt;
    req_kind_t         kind;
    logic [NUM_INTR-1:0] cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_thr_q <= LVL_W'(LVL_RESET);
            rd_thr_q   <= LVL_W'(LVL_RESET);
        end else if (lvl_wr) begin
            prog_thr_q <= lvl_prog_thr;
            rd_thr_q   <= lvl_rd_thr;
        end
    end

    fsq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_prog_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (prog_push),
        .wdata (prog_wdata),
        .pop   (prog_pop),
        .rdata (prog_head),
        .count (prog_cnt),
        .full  (prog_full),
        .empty (prog_empty)
    );

    fsq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rd_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (rd_push),
        .wdata (rd_push_data),
        .pop   (rd_pop),
        .rdata (rd_rdata),
        .count (rd_cnt),
        .full  (rd_full),
        .empty (rd_empty)
    );

    fsq_ctrl #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .WORD_LG (WORD_LG),
        .PAGE_LG (PAGE_LG),
        .BANK_LG (BANK_LG)
    ) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cmd_start       (cmd_start),
        .cmd_op          (cmd_op),
        .cmd_bank        (cmd_bank_sel),
        .cmd_count       (cmd_count),
        .cmd_addr        (cmd_addr),
        .status_clr      (status_clr),
        .rd_fifo_full    (rd_full),
        .prog_fifo_empty (prog_empty),
        .prog_head       (prog_head),
        .fl_rd_done      (fl_rd_done),
        .fl_prog_done    (fl_prog_done),
        .fl_erase_done   (fl_erase_done),
        .fl_rdata        (fl_rdata),
        .rd_push         (rd_push),
        .rd_push_data    (rd_push_data),
        .prog_pop        (prog_pop),
        .fl_req          (fl_req),
        .fl_addr         (fl_addr),
        .fl_kind         (kind),
        .fl_wdata        (fl_wdata),
        .busy            (busy),
        .done_evt        (done_evt),
        .err_evt         (err_evt),
        .stat_done       (op_done),
        .stat_err        (op_err)
    );

    assign fl_rd       = kind.rd;
    assign fl_prog     = kind.prog;
    assign fl_pg_erase = kind.pg_erase;
    assign fl_bk_erase = kind.bk_erase;

    always_comb begin
        cond                = '0;
        cond[IX_PROG_EMPTY] = prog_empty;
        cond[IX_PROG_LVL]   = int'(prog_cnt) <= int'(prog_thr_q);
        cond[IX_RD_FULL]    = rd_full;
        cond[IX_RD_LVL]     = int'(rd_cnt) >= int'(rd_thr_q);
        cond[IX_OP_DONE]    = done_evt;
        cond[IX_OP_ERR]     = err_evt;
    end

    fsq_intr #(
        .N         (NUM_INTR),
        .EDGE_MASK (EDGE_MASK),
        .COND_RST  (COND_RST)
    ) u_intr (
        .clk   (clk),
        .rst   (rst),
        .cond  (cond),
        .clr   (intr_clr),
        .test  (intr_test),
        .en    (intr_en),
        .state (intr_state),
        .irq   (irq)
    );

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
    parameter int DATA_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              fl_req,
    input logic [31:0]       fl_addr,
    input logic              fl_rd,
    input logic              fl_prog,
    input logic              fl_pg_erase,
    input logic              fl_bk_erase,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              fl_rd_done,
    input logic              fl_prog_done,
    input logic              fl_erase_done,
    input logic              rd_full,
    input logic              rd_empty,
    input logic              prog_empty,
    input logic              fifo_clr,
    input logic [5:0]        intr_test,
    input logic [5:0]        intr_state
);

    p_one_kind_r1: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> $onehot({fl_rd, fl_prog, fl_pg_erase, fl_bk_erase}));

    p_word_align_r3: assert property (@(posedge clk) disable iff (rst)
        (fl_req && (fl_rd || fl_prog)) |-> ((fl_addr & 32'(WORD_BYTES - 1)) == 32'd0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !(fl_rd_done || fl_prog_done || fl_erase_done))
        |=> (fl_req && $stable(fl_addr) && $stable(fl_wdata)
             && $stable({fl_rd, fl_prog, fl_pg_erase, fl_bk_erase})));

    p_rd_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_rd) |-> !rd_full);

    p_prog_src_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(fl_req) && fl_prog) |-> $past(!prog_empty));

    p_test_force_r10: assert property (@(posedge clk) disable iff (rst)
        (intr_test != 6'd0) |=> ((intr_state & $past(intr_test)) == $past(intr_test)));

    p_fifo_clr_r12: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (rd_empty && prog_empty));

endmodule

bind flash_op_sequencer fsq_checker #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_fsq_checker (
    .clk           (clk),
    .rst           (rst),
    .fl_req        (fl_req),
    .fl_addr       (fl_addr),
    .fl_rd         (fl_rd),
    .fl_prog       (fl_prog),
    .fl_pg_erase   (fl_pg_erase),
    .fl_bk_erase   (fl_bk_erase),
    .fl_wdata      (fl_wdata),
    .fl_rd_done    (fl_rd_done),
    .fl_prog_done  (fl_prog_done),
    .fl_erase_done (fl_erase_done),
    .rd_full       (rd_full),
    .rd_empty      (rd_empty),
    .prog_empty    (prog_empty),
    .fifo_clr      (fifo_clr),
    .intr_test     (intr_test),
    .intr_state    (intr_state)
);

// File: tb/flash_op_sequencer_test.sv
`timescale 1ns/1ps
module flash_op_sequencer_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        cmd_start, cmd_bank_sel, fifo_clr, lvl_wr, prog_push, rd_pop;
    logic [1:0]  cmd_op, status_clr;
    logic [11:0] cmd_count;
    logic [31:0] cmd_addr, prog_wdata, rd_rdata, fl_addr, fl_wdata, fl_rdata;
    logic [4:0]  lvl_prog_thr, lvl_rd_thr;
    logic        prog_full, prog_empty, rd_full, rd_empty;
    logic [5:0]  intr_en, intr_clr, intr_test, intr_state, irq;
    logic        op_done, op_err, busy;
    logic        fl_req, fl_rd, fl_prog, fl_pg_erase, fl_bk_erase;
    logic        fl_rd_done, fl_prog_done, fl_erase_done;

    flash_op_sequencer uut (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h00C3_5A5A;
    endfunction

    // back-end model: answers each held request after lat cycles
    int lat = 1;
    int wcnt = 0;
    int log_n = 0;
    int stall_viol = 0;
    logic [31:0] log_addr [0:511];
    logic [3:0]  log_kind [0:511];
    logic [31:0] log_wd   [0:511];

    always @(negedge clk) begin
        fl_rd_done = 1'b0;
        fl_prog_done = 1'b0;
        fl_erase_done = 1'b0;
        if (rst) begin
            wcnt = 0;
        end else if (fl_req) begin
            if (fl_rd && rd_full) stall_viol++;
            if (wcnt >= lat) begin
                wcnt = 0;
                if (log_n < 512) begin
                    log_addr[log_n] = fl_addr;
                    log_kind[log_n] = {fl_rd, fl_prog, fl_pg_erase, fl_bk_erase};
                    log_wd[log_n]   = fl_wdata;
                end
                log_n++;
                fl_rdata = rd_pat(fl_addr);
                if (fl_rd) fl_rd_done = 1'b1;
                if (fl_prog) fl_prog_done = 1'b1;
                if (fl_pg_erase || fl_bk_erase) fl_erase_done = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] op, input logic bank, input int cnt, input logic [31:0] a);
        @(negedge clk);
        cmd_op = op; cmd_bank_sel = bank; cmd_count = 12'(cnt); cmd_addr = a; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        intr_clr = 6'h3F; status_clr = 2'b11;
        @(negedge clk);
        intr_clr = 6'h00; status_clr = 2'b00;
    endtask

    task automatic pulse_fifo_clr();
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        prog_wdata = w; prog_push = 1'b1;
        @(negedge clk);
        prog_push = 1'b0;
    endtask

    // random read: pops with random gaps, checks order of data
    task automatic rand_read(input logic [31:0] a, input int cnt);
        int base, popped, bad;
        logic [31:0] wa;
        base = log_n; popped = 0; bad = 0;
        wa = a & 32'hFFFF_FFFC;
        start(2'd0, 1'b0, cnt, a);
        for (int g = 0; g < 20000 && popped < cnt; g++) begin
            rd_pop = 1'b0;
            if (!rd_empty && ($urandom % 4) != 0) begin
                if (rd_rdata !== rd_pat(wa + 32'(4 * popped))) bad++;
                rd_pop = 1'b1;
                popped++;
            end
            @(negedge clk);
        end
        rd_pop = 1'b0;
        wait_idle();
        for (int i = 0; i < cnt; i++)
            if (log_addr[base+i] !== wa + 32'(4 * i) || log_kind[base+i] !== 4'b1000) bad++;
        check("R7 random read data/address mismatches", 64'(bad), 64'd0);
        check("R2 random read request count", 64'(log_n - base), 64'(cnt));
    endtask

    task automatic rand_prog(input logic [31:0] a, input int cnt);
        int base, pushed, bad;
        logic [31:0] wa;
        logic [31:0] pw [0:63];
        base = log_n; pushed = 0; bad = 0;
        wa = a & 32'hFFFF_FFFC;
        for (int i = 0; i < 64; i++) pw[i] = $urandom;
        start(2'd1, 1'b0, cnt, a);
        for (int g = 0; g < 20000 && pushed < cnt; g++) begin
            prog_push = 1'b0;
            if (!prog_full && ($urandom % 3) != 0) begin
                prog_wdata = pw[pushed];
                prog_push = 1'b1;
                pushed++;
            end
            @(negedge clk);
        end
        prog_push = 1'b0;
        wait_idle();
        for (int i = 0; i < cnt; i++)
            if (log_addr[base+i] !== wa + 32'(4 * i) || log_wd[base+i] !== pw[i]
                || log_kind[base+i] !== 4'b0100) bad++;
        check("R6 random program order/address mismatches", 64'(bad), 64'd0);
        check("R9 random program done status", 64'(op_done), 64'd1);
    endtask

    initial begin
        int base, bad;
        logic [31:0] w0, w2, w3;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        cmd_start = 0; cmd_bank_sel = 0; fifo_clr = 0; lvl_wr = 0; prog_push = 0; rd_pop = 0;
        cmd_op = 0; status_clr = 0; cmd_count = 0; cmd_addr = 0; prog_wdata = 0;
        lvl_prog_thr = 0; lvl_rd_thr = 0; intr_en = 0; intr_clr = 0; intr_test = 0;
        fl_rdata = 0; fl_rd_done = 0; fl_prog_done = 0; fl_erase_done = 0;
        cyc(4);
        rst = 1'b0;
        cyc(3);

        // reset state
        check("R11 no interrupt out of reset", 64'(intr_state), 64'd0);
        check("R7 read FIFO empty after reset", 64'(rd_empty), 64'd1);
        check("R12 program FIFO empty after reset", 64'(prog_empty), 64'd1);
        check("R2 idle after reset", 64'({busy, fl_req, op_done, op_err}), 64'd0);

        // long read that fills the FIFO, unaligned start
        lat = 0;
        base = log_n;
        start(2'd0, 1'b0, 20, 32'h13);
        for (int g = 0; g < 500 && !rd_full; g++) @(negedge clk);
        cyc(30);
        check("R5 requests stop at 16 while read FIFO full", 64'(log_n - base), 64'd16);
        check("R5 still busy while stalled", 64'(busy), 64'd1);
        check("R11 read-full interrupt", 64'(intr_state[2]), 64'd1);
        check("R11 read-level interrupt at threshold 15", 64'(intr_state[3]), 64'd1);
        check("R3 read start aligned down 0x13 to 0x10", 64'(log_addr[base]), 64'h10);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            for (int g = 0; g < 500 && rd_empty; g++) @(negedge clk);
            if (rd_rdata !== rd_pat(32'h10 + 32'(4 * i))) bad++;
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        check("R7 read data in address order after resume", 64'(bad), 64'd0);
        wait_idle();
        check("R2 read issues count requests", 64'(log_n - base), 64'd20);
        check("R5 no read request while FIFO full", 64'(stall_viol), 64'd0);
        check("R9 done status after read", 64'(op_done), 64'd1);
        check("R9 op-done interrupt bit 4", 64'(intr_state[4]), 64'd1);
        clear_all();
        check("R9 status_clr clears done", 64'(op_done), 64'd0);

        // program stall and page crossing
        lat = 2;
        base = log_n;
        push_word(32'hA000_0001);
        push_word(32'hA000_0002);
        start(2'd1, 1'b0, 6, 32'h3F8);
        cyc(60);
        check("R6 program stalls on empty FIFO", 64'(log_n - base), 64'd2);
        check("R6 busy while waiting for data", 64'(busy), 64'd1);
        for (int i = 3; i <= 6; i++) push_word(32'hA000_0000 + 32'(i));
        wait_idle();
        bad = 0;
        for (int i = 0; i < 6; i++)
            if (log_addr[base+i] !== 32'h3F8 + 32'(4 * i) || log_wd[base+i] !== 32'hA000_0001 + 32'(i)) bad++;
        check("R4 program crosses page boundary with +4 steps", 64'(bad), 64'd0);
        check("R11 program-empty interrupt", 64'(intr_state[0]), 64'd1);
        clear_all();

        // erases ignore count and align
        base = log_n;
        start(2'd2, 1'b0, 7, 32'h1234);
        wait_idle();
        check("R8 page erase single request", 64'(log_n - base), 64'd1);
        check("R3 page erase aligned to 0x1000", 64'(log_addr[base]), 64'h1000);
        check("R1 page erase kind", 64'(log_kind[base]), 64'b0010);
        check("R8 done after erase", 64'(op_done), 64'd1);
        clear_all();
        base = log_n;
        start(2'd2, 1'b1, 3, 32'h0004_5678);
        wait_idle();
        check("R8 bank erase single request", 64'(log_n - base), 64'd1);
        check("R3 bank erase aligned to 0x40000", 64'(log_addr[base]), 64'h40000);
        check("R1 bank erase kind", 64'(log_kind[base]), 64'b0001);
        clear_all();

        // reserved op
        base = log_n;
        start(2'd3, 1'b0, 4, 32'h80);
        cyc(5);
        check("R1 reserved op sets error", 64'({op_err, intr_state[5], op_done}), 64'b110);
        check("R1 reserved op issues no request", 64'(log_n - base), 64'd0);
        clear_all();

        // zero count and start while busy
        base = log_n;
        start(2'd0, 1'b0, 0, 32'h40);
        cyc(3);
        check("R2 zero count completes with no request", 64'({op_done, 1'(log_n != base)}), 64'b10);
        clear_all();
        lat = 6;
        base = log_n;
        start(2'd0, 1'b0, 3, 32'h500);
        start(2'd2, 1'b1, 1, 32'h0);
        wait_idle();
        bad = 0;
        for (int i = 0; i < 3; i++) if (log_kind[base+i] !== 4'b1000) bad++;
        check("R2 start while busy ignored", 64'(log_n - base), 64'd3);
        check("R2 only reads issued", 64'(bad), 64'd0);
        pulse_fifo_clr();
        check("R12 FIFO reset empties read FIFO", 64'(rd_empty), 64'd1);
        clear_all();

        // interrupt enable/test/clear
        @(negedge clk); intr_test = 6'b100001;
        @(negedge clk); intr_test = 6'b000000;
        check("R10 test forces bits", 64'(intr_state), 64'b100001);
        check("R10 irq masked when disabled", 64'(irq), 64'd0);
        intr_en = 6'b000001;
        @(negedge clk);
        check("R10 irq follows enable", 64'(irq), 64'b000001);
        intr_clr = 6'b000001;
        @(negedge clk); intr_clr = 6'b0;
        check("R10 write-1 clears only that bit", 64'(intr_state), 64'b100000);
        intr_en = 6'b0;
        clear_all();

        // level thresholds
        @(negedge clk); lvl_wr = 1'b1; lvl_rd_thr = 5'd4; lvl_prog_thr = 5'd2;
        @(negedge clk); lvl_wr = 1'b0;
        lat = 1;
        start(2'd0, 1'b0, 4, 32'h100);
        wait_idle();
        cyc(2);
        check("R11 read level at threshold 4 without full", 64'(intr_state[3:2]), 64'b10);
        pulse_fifo_clr();
        for (int i = 0; i < 4; i++) push_word(32'hC000_0000 + 32'(i));
        clear_all();
        start(2'd1, 1'b0, 4, 32'h200);
        wait_idle();
        cyc(2);
        check("R11 program level when drained to 2", 64'(intr_state[1]), 64'd1);
        clear_all();

        // FIFO reset with program word in flight
        lat = 8;
        base = log_n;
        w0 = 32'h1111_0000; w2 = 32'h2222_0002; w3 = 32'h3333_0003;
        push_word(w0);
        push_word(32'hDEAD_0001);
        start(2'd1, 1'b0, 3, 32'h300);
        for (int g = 0; g < 200 && !fl_req; g++) @(negedge clk);
        pulse_fifo_clr();
        check("R12 program FIFO emptied", 64'(prog_empty), 64'd1);
        check("R12 in-flight word held", 64'({fl_req, fl_wdata}), {31'd0, 1'b1, w0});
        push_word(w2);
        push_word(w3);
        wait_idle();
        bad = 0;
        if (log_wd[base] !== w0 || log_wd[base+1] !== w2 || log_wd[base+2] !== w3) bad++;
        if (log_n - base != 3) bad++;
        check("R12 transaction continues with new words", 64'(bad), 64'd0);
        clear_all();

        // constrained random transactions
        for (int t = 0; t < 8; t++) begin
            lat = $urandom % 4;
            if ($urandom % 2) rand_read($urandom % 32'h0010_0000, 1 + ($urandom % 40));
            else              rand_prog($urandom % 32'h0010_0000, 1 + ($urandom % 40));
            clear_all();
        end
        check("R5 no read request while FIFO full overall", 64'(stall_viol), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule